// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Control with Unmask Sweep

This block holds the configuration-space registers of an MSI-X capability. It answers dword reads of the message-control word and of the two locator registers that point at the vector table and the pending-bit array. It also computes, from parameters, how large the base address region must become so that the interrupt page has room of its own. Software can change only two bits, the function enable and the function mask-all. Both sit in the upper byte of the message-control word.

When a configuration write touches that control byte and leaves the function enabled, the block pulses a request to drop the legacy wired interrupt. If the function is not masked, it then sweeps the vectors one per clock, lowest first. For each vector the companion table block reports whether the vector is pending and whether its own mask bit is set. The sweep asks the table block to deliver each vector that is pending and unmasked. Table storage and capability-list linkage live elsewhere.

Top module: `msix_cap_ctrl`

## Requirements
- R1: A read at dword index 0 returns bits [15:0] = 0, bits [26:16] = NUM_VEC-1, bits [29:27] = 0, bit 30 = function mask-all and bit 31 = function enable. Dword index 3 reads as zero.
- R2: Only bits 31 and 30 of dword 0 can be written, and only through byte enable 3. Writes to any other bit, lane or dword leave every readback value unchanged.
- R3: Dword index 1 (table locator) reads as the base OR BAR_IDX. The base is 4096 when BAR_SIZE is nonzero and below 4096, and is BAR_SIZE otherwise.
- R4: Dword index 2 (pending-array locator) reads as (that base + 0x800) OR BAR_IDX.
- R5: bar_size_o is 4096 for BAR_SIZE = 0, 8192 for 0 < BAR_SIZE < 4096, and 2*BAR_SIZE otherwise, on a 33-bit port. NUM_VEC outside 1..32, BAR_SIZE above 0x8000_0000 or BAR_IDX above 5 stops elaboration.
- R6: After reset, enable and mask-all are 0, intx_deassert_o is 0 and the sweep is idle.
- R7: A write that does not include byte 3 of dword 0 causes no interrupt-drop pulse and does not start, stop or restart a sweep.
- R8: A write to the control byte that clears enable causes no interrupt-drop pulse and stops any sweep in progress by the next cycle.
- R9: A write to the control byte that sets enable gives intx_deassert_o high for exactly the one cycle after the write edge. If it also sets mask-all, no sweep runs.
- R10: A write that sets enable and clears mask-all makes scan_busy_o high for exactly NUM_VEC cycles, starting the cycle after the write edge. In the k-th of those cycles (k from 0), fire_o is high with fire_vec_o = k exactly when vec_pend_i[k] is 1 and vec_mask_i[k] is 0.
- R11: A control-byte write that sets enable and clears mask-all while a sweep runs restarts the sweep at vector 0 with a full NUM_VEC-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Dword index within the capability |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i (combinational) |
| vec_pend_i | input | NUM_VEC | Pending bit per vector from the table block |
| vec_mask_i | input | NUM_VEC | Per-vector mask bit from the table block |
| bar_size_o | output | 33 | Enlarged region size |
| msix_en_o | output | 1 | Function enable |
| func_mask_o | output | 1 | Function mask-all |
| intx_deassert_o | output | 1 | One-cycle request to drop the legacy interrupt |
| scan_busy_o | output | 1 | Sweep in progress |
| fire_o | output | 1 | Deliver-and-clear request for fire_vec_o |
| fire_vec_o | output | VW | Vector examined this cycle |

## Verification
The sweep is driven with every combination of pending bits and per-vector mask bits over six vectors. This shows that delivery needs both conditions and that each vector shows up in its own cycle, in ascending order. Separate control writes set enable with mask-all, clear enable, or miss byte lane 3, and each should produce a different set of pulses. A write in the middle of a sweep shows the difference between a restart and a sweep that runs on. Three region sizes (zero, below a page, and the 2 GB limit) separate the three sizing branches and the locator values.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;

  localparam logic [31:0] PAGE_BYTES = 32'h0000_1000;
  localparam logic [31:0] PEND_SPLIT = 32'h0000_0800;
  localparam logic [31:0] SIZE_LIMIT = 32'h8000_0000;

  // Dword indices inside the capability
  localparam logic [1:0] DW_CTRL = 2'd0;
  localparam logic [1:0] DW_TBL  = 2'd1;
  localparam logic [1:0] DW_PBA  = 2'd2;

  // Bit positions inside dword 0
  localparam int EN_BIT    = 31;
  localparam int FMASK_BIT = 30;
  localparam int CTRL_LANE = 3;

  // Base the table sits on: a sub-page region is rounded up to a page
  function automatic logic [31:0] table_base(input logic [31:0] orig);
    if (orig != 32'd0 && orig < PAGE_BYTES) return PAGE_BYTES;
    return orig;
  endfunction

  // Region size once the interrupt page is added
  function automatic logic [32:0] grown_size(input logic [31:0] orig);
    if (orig == 32'd0) return {1'b0, PAGE_BYTES};
    return {table_base(orig), 1'b0};
  endfunction

  function automatic logic [31:0] table_locator(input logic [31:0] orig,
                                                input logic [2:0] bir);
    return table_base(orig) | {29'd0, bir};
  endfunction

  function automatic logic [31:0] pend_locator(input logic [31:0] orig,
                                               input logic [2:0] bir);
    return (table_base(orig) + PEND_SPLIT) | {29'd0, bir};
  endfunction

endpackage

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 8,
  parameter logic [31:0] BAR_SIZE = 32'h0000_0300,
  parameter int unsigned BAR_IDX  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_i,
  input  logic [1:0]  cfg_addr_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic        en_o,
  output logic        fmask_o,
  output logic        ctrl_hit_o,
  output logic        sweep_start_o,
  output logic        sweep_stop_o,
  output logic        intx_o
);

  localparam logic [2:0]  BIR     = 3'(BAR_IDX);
  localparam logic [10:0] QSIZE   = 11'(NUM_VEC - 1);
  localparam logic [31:0] TBL_VAL = table_locator(BAR_SIZE, BIR);
  localparam logic [31:0] PBA_VAL = pend_locator(BAR_SIZE, BIR);

  logic en_q, fm_q, intx_q;
  logic wr_en_bit, wr_fm_bit;

  assign ctrl_hit_o    = cfg_wr_i && (cfg_addr_i == DW_CTRL) && cfg_be_i[CTRL_LANE];
  assign wr_en_bit     = cfg_wdata_i[EN_BIT];
  assign wr_fm_bit     = cfg_wdata_i[FMASK_BIT];
  assign sweep_start_o = ctrl_hit_o && wr_en_bit && !wr_fm_bit;
  assign sweep_stop_o  = ctrl_hit_o && !sweep_start_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fm_q   <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      intx_q <= ctrl_hit_o && wr_en_bit;
      if (ctrl_hit_o) begin
        en_q <= wr_en_bit;
        fm_q <= wr_fm_bit;
      end
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      DW_CTRL: cfg_rdata_o = {en_q, fm_q, 3'b000, QSIZE, 16'h0000};
      DW_TBL:  cfg_rdata_o = TBL_VAL;
      DW_PBA:  cfg_rdata_o = PBA_VAL;
      default: cfg_rdata_o = 32'h0000_0000;
    endcase
  end

  assign en_o    = en_q;
  assign fmask_o = fm_q;
  assign intx_o  = intx_q;

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !ctrl_hit_o) |=> ($stable(en_q) && $stable(fm_q))) else $error("control bits moved"); // R7
  AST_INTX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_q && !$past(ctrl_hit_o, 1)) |-> 1'b0 || $past(ctrl_hit_o)) else $error("stray intx"); // R9
  AST_INTX_EN: assert property (@(posedge clk) disable iff (!rst_n)
    intx_q |-> en_q) else $error("intx while disabled"); // R8

endmodule

// File: rtl/msix_cap_sweep.sv
module msix_cap_sweep #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [NUM_VEC-1:0] pend_i,
  input  logic [NUM_VEC-1:0] vmask_i,
  output logic               busy_o,
  output logic [VW-1:0]      idx_o,
  output logic               fire_o
);

  localparam logic [VW-1:0] LAST = VW'(NUM_VEC - 1);

  logic          busy_q;
  logic [VW-1:0] idx_q;
  logic          at_last;

  assign at_last = (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (stop_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (at_last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign fire_o = busy_q && pend_i[idx_q] && !vmask_i[idx_q];

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= LAST)) else $error("index past end"); // R10
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && !stop_i && !at_last) |=> (busy_q && idx_q == VW'($past(idx_q) + 1'b1))) else $error("index skipped"); // R10
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && idx_q == '0)) else $error("no restart"); // R11
  AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !busy_q) else $error("sweep not stopped"); // R8

endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
  import msix_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 8,
  parameter logic [31:0] BAR_SIZE = 32'h0000_0300,
  parameter int unsigned BAR_IDX  = 0,
  localparam int unsigned VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [3:0]         cfg_be_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_VEC-1:0] vec_pend_i,
  input  logic [NUM_VEC-1:0] vec_mask_i,
  output logic [32:0]        bar_size_o,
  output logic               msix_en_o,
  output logic               func_mask_o,
  output logic               intx_deassert_o,
  output logic               scan_busy_o,
  output logic               fire_o,
  output logic [VW-1:0]      fire_vec_o
);

  if (NUM_VEC < 1 || NUM_VEC > 32) begin : g_bad_count
    $error("NUM_VEC must lie in 1..32");
  end
  if (BAR_SIZE > SIZE_LIMIT) begin : g_bad_size
    $error("BAR_SIZE above the 2 GB limit");
  end
  if (BAR_IDX > 5) begin : g_bad_idx
    $error("BAR_IDX above 5");
  end

  // Events between the register file and the sweep, named for the checks
  logic ctrl_hit, sweep_start, sweep_stop;
  logic en_w, fm_w, sweep_fire;

  assign bar_size_o = grown_size(BAR_SIZE);

  msix_cap_regs #(
    .NUM_VEC (NUM_VEC),
    .BAR_SIZE(BAR_SIZE),
    .BAR_IDX (BAR_IDX)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_be_i     (cfg_be_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .en_o         (en_w),
    .fmask_o      (fm_w),
    .ctrl_hit_o   (ctrl_hit),
    .sweep_start_o(sweep_start),
    .sweep_stop_o (sweep_stop),
    .intx_o       (intx_deassert_o)
  );

  msix_cap_sweep #(
    .NUM_VEC(NUM_VEC)
  ) u_sweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(sweep_start),
    .stop_i (sweep_stop),
    .pend_i (vec_pend_i),
    .vmask_i(vec_mask_i),
    .busy_o (scan_busy_o),
    .idx_o  (fire_vec_o),
    .fire_o (sweep_fire)
  );

  assign msix_en_o   = en_w;
  assign func_mask_o = fm_w;
  assign fire_o      = sweep_fire && en_w && !fm_w;

  AST_FIRE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_fire |-> (en_w && !fm_w)) else $error("fire while masked"); // R10
  AST_START_WITH_INTX: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> (intx_deassert_o && scan_busy_o)) else $error("sweep without intx drop"); // R9
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && cfg_wdata_i[FMASK_BIT]) |=> !scan_busy_o) else $error("sweep under mask-all"); // R9

endmodule

// File: tb/msix_cap_ctrl_tb.sv
`timescale 1ns/1ps
module msix_cap_ctrl_tb;

  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [3:0] cfg_be = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [NV-1:0] pend = '0, vmask = '0;

  logic [31:0] rd_a, rd_z, rd_b;
  logic [32:0] bs_a, bs_z, bs_b;
  logic en_a, fm_a, intx_a, busy_a, fire_a;
  logic [2:0] vec_a;
  logic en_z, fm_z, intx_z, busy_z, fire_z;
  logic [0:0] vec_z;
  logic en_b, fm_b, intx_b, busy_b, fire_b;
  logic [4:0] vec_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msix_cap_ctrl #(.NUM_VEC(NV), .BAR_SIZE(32'h0000_0300), .BAR_IDX(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_a),
    .vec_pend_i(pend), .vec_mask_i(vmask), .bar_size_o(bs_a),
    .msix_en_o(en_a), .func_mask_o(fm_a), .intx_deassert_o(intx_a),
    .scan_busy_o(busy_a), .fire_o(fire_a), .fire_vec_o(vec_a));

  msix_cap_ctrl #(.NUM_VEC(1), .BAR_SIZE(32'h0), .BAR_IDX(0)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_z),
    .vec_pend_i(1'b0), .vec_mask_i(1'b0), .bar_size_o(bs_z),
    .msix_en_o(en_z), .func_mask_o(fm_z), .intx_deassert_o(intx_z),
    .scan_busy_o(busy_z), .fire_o(fire_z), .fire_vec_o(vec_z));

  msix_cap_ctrl #(.NUM_VEC(32), .BAR_SIZE(32'h8000_0000), .BAR_IDX(5)) u_dut_big (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_b),
    .vec_pend_i(32'h0), .vec_mask_i(32'h0), .bar_size_o(bs_b),
    .msix_en_o(en_b), .func_mask_o(fm_b), .intx_deassert_o(intx_b),
    .scan_busy_o(busy_b), .fire_o(fire_b), .fire_vec_o(vec_b));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected values from the sizing rules, stated case by case
  function automatic logic [32:0] exp_size(input logic [31:0] s);
    if (s == 0) return 33'd4096;
    else if (s < 32'd4096) return 33'd8192;
    else return 33'(s) * 33'd2;
  endfunction

  function automatic logic [31:0] exp_tbl(input logic [31:0] s, input int bir);
    logic [31:0] b;
    b = (s > 0 && s < 32'd4096) ? 32'd4096 : s;
    return b + 32'(bir);
  endfunction

  function automatic logic [31:0] exp_ctrl(input bit en, input bit fm, input int nv);
    return (32'(en) << 31) + (32'(fm) << 30) + (32'(nv - 1) << 16);
  endfunction

  // One-cycle write; returns at the negedge just after the capturing edge
  task automatic cfg_write(input logic [1:0] a, input logic [3:0] be,
                           input logic [31:0] d);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [31:0] exp,
                          input string req);
    cfg_addr = a;
    #0.5;
    check(rd_a == exp, req, 64'(rd_a), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    check(!en_a && !fm_a, "R6 ctrl bits", {en_a, fm_a}, 0);
    check(!intx_a && !busy_a, "R6 idle", {intx_a, busy_a}, 0);
    read_chk(2'd0, exp_ctrl(0, 0, NV), "R1 ctrl word after reset");
    read_chk(2'd3, 32'd0, "R1 dword 3");

    // R3 R4 R5 across three sizing branches
    cfg_addr = 2'd1; #0.5;
    check(rd_a == exp_tbl(32'h300, 2), "R3 small", 64'(rd_a), 64'(exp_tbl(32'h300, 2)));
    check(rd_z == exp_tbl(32'h0, 0), "R3 zero", 64'(rd_z), 64'(exp_tbl(32'h0, 0)));
    check(rd_b == exp_tbl(32'h8000_0000, 5), "R3 big", 64'(rd_b), 64'(exp_tbl(32'h8000_0000, 5)));
    cfg_addr = 2'd2; #0.5;
    check(rd_a == exp_tbl(32'h300, 2) + 32'h800, "R4 small", 64'(rd_a), 64'(exp_tbl(32'h300, 2) + 32'h800));
    check(rd_z == 32'h800, "R4 zero", 64'(rd_z), 64'h800);
    check(rd_b == 32'h8000_0805, "R4 big", 64'(rd_b), 64'h8000_0805);
    check(bs_a == exp_size(32'h300), "R5 small", 64'(bs_a), 64'(exp_size(32'h300)));
    check(bs_z == exp_size(32'h0), "R5 zero", 64'(bs_z), 64'(exp_size(32'h0)));
    check(bs_b == exp_size(32'h8000_0000), "R5 big", 64'(bs_b), 64'(exp_size(32'h8000_0000)));
    cfg_addr = 2'd0;
    @(negedge clk);

    // R9 enable with mask-all: intx pulse, no sweep; R2 read-only bits
    cfg_write(2'd0, 4'hF, 32'hFFFF_FFFF);
    check(intx_a == 1'b1, "R9 intx pulse", intx_a, 1);
    check(busy_a == 1'b0, "R9 no sweep under mask-all", busy_a, 0);
    read_chk(2'd0, exp_ctrl(1, 1, NV), "R2 only en/mask written");
    @(negedge clk);
    check(intx_a == 1'b0, "R9 pulse one cycle", intx_a, 0);
    check(rd_b == exp_ctrl(1, 1, 32) && rd_z == exp_ctrl(1, 1, 1), "R1 size field",
          {rd_b, rd_z}, {exp_ctrl(1, 1, 32), exp_ctrl(1, 1, 1)});

    // R7 R2 writes missing byte 3
    cfg_write(2'd0, 4'h7, 32'h0000_0000);
    check(intx_a == 1'b0 && busy_a == 1'b0, "R7 no side effect", {intx_a, busy_a}, 0);
    read_chk(2'd0, exp_ctrl(1, 1, NV), "R7 ctrl unchanged");
    cfg_write(2'd1, 4'hF, 32'h0000_0000);
    read_chk(2'd1, exp_tbl(32'h300, 2), "R2 table locator read-only");
    cfg_write(2'd2, 4'hF, 32'h0000_0000);
    read_chk(2'd2, exp_tbl(32'h300, 2) + 32'h800, "R2 pend locator read-only");
    cfg_addr = 2'd0;

    // R8 write clearing enable
    cfg_write(2'd0, 4'h8, 32'h0000_0000);
    check(intx_a == 1'b0 && busy_a == 1'b0, "R8 disabled write", {intx_a, busy_a}, 0);
    read_chk(2'd0, exp_ctrl(0, 0, NV), "R8 ctrl cleared");

    // R10 exhaustive sweep over pending and mask patterns
    for (int p = 0; p < (1 << NV); p++) begin
      for (int m = 0; m < (1 << NV); m++) begin
        pend = NV'(p); vmask = NV'(m);
        cfg_write(2'd0, 4'h8, 32'h8000_0000);
        for (int k = 0; k < NV; k++) begin
          bit ef;
          ef = pend[k] && !vmask[k];
          check(busy_a == 1'b1, "R10 busy window", busy_a, 1);
          check(fire_a == ef, "R10 fire", fire_a, ef);
          if (ef) check(vec_a == 3'(k), "R10 vector order", vec_a, k);
          check(intx_a == (k == 0), "R9 intx timing", intx_a, (k == 0));
          @(negedge clk);
        end
        check(busy_a == 1'b0 && fire_a == 1'b0, "R10 sweep end", {busy_a, fire_a}, 0);
      end
    end

    // R11 restart mid-sweep
    pend = '1; vmask = '0;
    cfg_write(2'd0, 4'h8, 32'h8000_0000);
    @(negedge clk); @(negedge clk);
    check(vec_a == 3'd2, "R11 mid sweep position", vec_a, 2);
    cfg_write(2'd0, 4'h8, 32'h8000_0000);
    for (int k = 0; k < NV; k++) begin
      check(busy_a && fire_a && vec_a == 3'(k), "R11 restart order", {busy_a, fire_a, vec_a}, {2'b11, 3'(k)});
      @(negedge clk);
    end
    check(busy_a == 1'b0, "R11 full window then idle", busy_a, 0);

    // R7 write missing the control lane does not disturb a running sweep
    cfg_write(2'd0, 4'h8, 32'h8000_0000);
    cfg_write(2'd0, 4'h7, 32'h0000_0000);
    check(busy_a && vec_a == 3'd1, "R7 sweep undisturbed", {busy_a, vec_a}, {1'b1, 3'd1});
    // R8 disabling stops a running sweep
    cfg_write(2'd0, 4'h8, 32'h0000_0000);
    check(busy_a == 1'b0 && fire_a == 1'b0, "R8 sweep stopped", {busy_a, fire_a}, 0);
    check(intx_a == 1'b0, "R8 no intx", intx_a, 0);

    // R6 reset clears writable bits
    cfg_write(2'd0, 4'h8, 32'hC000_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!en_a && !fm_a && !busy_a && !intx_a, "R6 reset clears", {en_a, fm_a, busy_a, intx_a}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule